// File: doc/BRIEF.md
# Keyboard Scancode Make/Break Reader

This block receives the serial clock and data lines of a PS/2 keyboard. It brings both lines into the system clock domain and filters the keyboard clock. It then collects each 11-bit frame. The frame has a start bit, eight data bits sent least significant bit first, an odd parity bit and a stop bit.

Frames are not passed through one by one. A small sequencer reads the first frame of a key event as the code of the pressed key and reports it with a one-cycle strobe. It then looks at the frame after it. If that frame is the release prefix 0xF0, the next frame is the released key's code, and it is reported on a separate output with its own strobe. A consumer that only wants key presses can ignore the release output.

Each frame's parity and stop bit are checked and reported, but the result does not change the sequencing. A timeout drops a frame that stops part way through.

Top module: `ps2_scan_reader`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `make_valid_o`, `brk_valid_o` and `parity_err_o` are 0, and `make_code_o` and `brk_code_o` are 0x00.
- R2: A frame starts when the data line is low while the filtered clock is high. The block samples 11 bits on falling clock edges: frame bit 0 is the start bit, bits 1..8 are data bits D0..D7 (LSB first), bit 9 is parity and bit 10 is the stop bit. The frame is complete on the rising edge that follows the 11th falling edge.
- R3: The data byte of the first frame of a key event appears on `make_code_o`, and `make_valid_o` is high for exactly one cycle.
- R4: If the second frame's byte is 0xF0, the byte of the third frame appears on `brk_code_o`, and `brk_valid_o` is high for exactly one cycle. No make strobe is produced for the second or third frame.
- R5: If the second frame's byte is not 0xF0, that frame produces no strobe, and the next frame is treated as the first frame of a new key event.
- R6: `parity_err_o` pulses for one cycle for a completed frame whose eight data bits and parity bit hold an even number of ones, or whose stop bit is 0. The code outputs and strobes behave exactly as they would for a clean frame.
- R7: If no clock edge arrives for `TIMEOUT_CYC` cycles in the middle of a frame, the receiver goes back to idle. The partial bits are discarded, and the next full frame is decoded correctly.
- R8: `make_code_o` and `brk_code_o` keep their value between their strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| ps2_dat_i | input | 1 | Keyboard data line (asynchronous) |
| make_valid_o | output | 1 | One-cycle strobe for a pressed-key code |
| make_code_o | output | 8 | Code of the last pressed key |
| brk_valid_o | output | 1 | One-cycle strobe for a released-key code |
| brk_code_o | output | 8 | Code of the last released key |
| parity_err_o | output | 1 | One-cycle strobe for a frame with bad parity or stop bit |

## Verification
The sequencer is exercised with four kinds of key event:
- **Press then release of the same code.** This confirms that only the first and third frames produce strobes.
- **Release code different from the press code, with bytes 0x01 and 0x80.** These bytes expose any reversal of the bit order.
- **Second frame that is not 0xF0, including a repeat of the pressed code.** This shows the frame is dropped and the sequencer rearms.
- **Corrupted frames and a frame abandoned part way through.** Bad-parity and bad-stop frames show that frame checking is separate from sequencing. The abandoned frame tells a working timeout apart from a receiver that stays misaligned by the stale bits.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int FRAME_BITS = 11;
  localparam int DATA_BITS  = 8;
  localparam logic [DATA_BITS-1:0] REL_PREFIX = 8'hF0;

  typedef enum logic [1:0] {RX_IDLE, RX_WAIT_LO, RX_WAIT_HI} rx_state_t;
  typedef enum logic [1:0] {SQ_FIRST, SQ_SECOND, SQ_THIRD} sq_state_t;
endpackage

// File: rtl/ps2_line_cond.sv
module ps2_line_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ps2_clk_i,
  input  logic ps2_dat_i,
  output logic clk_lvl_o,
  output logic dat_o,
  output logic fall_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] clk_sync, dat_sync;
  logic [FILT_LEN-1:0]    hist;
  logic                   lvl_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sync <= '1;
      dat_sync <= '1;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], ps2_clk_i};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], ps2_dat_i};
    end
  end

  // clock level changes only after FILT_LEN equal samples
  always_comb begin
    lvl_next = clk_lvl_o;
    if (&hist)       lvl_next = 1'b1;
    else if (~|hist) lvl_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= '1;
      clk_lvl_o <= 1'b1;
      fall_o    <= 1'b0;
      rise_o    <= 1'b0;
    end else begin
      hist      <= {hist[FILT_LEN-2:0], clk_sync[SYNC_STAGES-1]};
      clk_lvl_o <= lvl_next;
      fall_o    <= clk_lvl_o & ~lvl_next;
      rise_o    <= ~clk_lvl_o & lvl_next;
    end
  end

  assign dat_o = dat_sync[SYNC_STAGES-1];
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clk_lvl_i,
  input  logic                 dat_i,
  input  logic                 fall_i,
  input  logic                 rise_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 fault_o
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam int WW = $clog2(TIMEOUT_CYC + 1);

  rx_state_t             st;
  logic [CW-1:0]         bit_cnt;
  logic [WW-1:0]         wd;
  logic [FRAME_BITS-1:0] shreg;
  logic                  par_bad, stop_bad;

  assign par_bad  = ~(^shreg[DATA_BITS+1:1]);
  assign stop_bad = ~shreg[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RX_IDLE;
      bit_cnt <= '0;
      wd      <= '0;
      shreg   <= '0;
      done_o  <= 1'b0;
      byte_o  <= '0;
      fault_o <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      case (st)
        RX_IDLE: begin
          wd      <= '0;
          bit_cnt <= '0;
          if (clk_lvl_i && !dat_i) st <= RX_WAIT_LO;
        end
        RX_WAIT_LO: begin
          if (fall_i) begin
            shreg <= {dat_i, shreg[FRAME_BITS-1:1]};
            wd    <= '0;
            st    <= RX_WAIT_HI;
          end else if (wd == WW'(TIMEOUT_CYC - 1)) begin
            st <= RX_IDLE;
          end else begin
            wd <= wd + 1'b1;
          end
        end
        RX_WAIT_HI: begin
          if (rise_i) begin
            wd <= '0;
            if (bit_cnt == CW'(FRAME_BITS - 1)) begin
              done_o  <= 1'b1;
              byte_o  <= shreg[DATA_BITS:1];
              fault_o <= par_bad | stop_bad;
              st      <= RX_IDLE;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              st      <= RX_WAIT_LO;
            end
          end else if (wd == WW'(TIMEOUT_CYC - 1)) begin
            st <= RX_IDLE;
          end else begin
            wd <= wd + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps2_key_seq.sv
module ps2_key_seq
  import ps2_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 done_i,
  input  logic [DATA_BITS-1:0] byte_i,
  input  logic                 fault_i,
  output logic                 make_valid_o,
  output logic [DATA_BITS-1:0] make_code_o,
  output logic                 brk_valid_o,
  output logic [DATA_BITS-1:0] brk_code_o,
  output logic                 parity_err_o
);
  sq_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= SQ_FIRST;
      make_valid_o <= 1'b0;
      make_code_o  <= '0;
      brk_valid_o  <= 1'b0;
      brk_code_o   <= '0;
      parity_err_o <= 1'b0;
    end else begin
      make_valid_o <= 1'b0;
      brk_valid_o  <= 1'b0;
      parity_err_o <= done_i & fault_i;
      if (done_i) begin
        case (st)
          SQ_FIRST: begin
            make_code_o  <= byte_i;
            make_valid_o <= 1'b1;
            st           <= SQ_SECOND;
          end
          SQ_SECOND: st <= (byte_i == REL_PREFIX) ? SQ_THIRD : SQ_FIRST;
          SQ_THIRD: begin
            brk_code_o  <= byte_i;
            brk_valid_o <= 1'b1;
            st          <= SQ_FIRST;
          end
          default: st <= SQ_FIRST;
        endcase
      end
    end
  end
endmodule

// File: rtl/ps2_scan_reader.sv
module ps2_scan_reader
  import ps2_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       make_valid_o,
  output logic [7:0] make_code_o,
  output logic       brk_valid_o,
  output logic [7:0] brk_code_o,
  output logic       parity_err_o
);
  logic                 clk_lvl, dat_s, fall, rise;
  logic                 done, fault;
  logic [DATA_BITS-1:0] rx_byte;

  ps2_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) cond_i (
    .clk(clk), .rst(rst), .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i),
    .clk_lvl_o(clk_lvl), .dat_o(dat_s), .fall_o(fall), .rise_o(rise)
  );

  ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) frame_i (
    .clk(clk), .rst(rst), .clk_lvl_i(clk_lvl), .dat_i(dat_s),
    .fall_i(fall), .rise_i(rise), .done_o(done), .byte_o(rx_byte),
    .fault_o(fault)
  );

  ps2_key_seq seq_i (
    .clk(clk), .rst(rst), .done_i(done), .byte_i(rx_byte), .fault_i(fault),
    .make_valid_o(make_valid_o), .make_code_o(make_code_o),
    .brk_valid_o(brk_valid_o), .brk_code_o(brk_code_o),
    .parity_err_o(parity_err_o)
  );
endmodule

// File: rtl/ps2_scan_reader_chk.sv
module ps2_scan_reader_chk (
  input logic       clk,
  input logic       rst,
  input logic       make_valid_o,
  input logic [7:0] make_code_o,
  input logic       brk_valid_o,
  input logic [7:0] brk_code_o,
  input logic       parity_err_o
);
  AST_MAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    make_valid_o |=> !make_valid_o); // R3
  AST_BRK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    brk_valid_o |=> !brk_valid_o); // R4
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(make_valid_o && brk_valid_o)); // R4
  AST_PERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    parity_err_o |=> !parity_err_o); // R6
  AST_MAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !make_valid_o |-> $stable(make_code_o)); // R8
  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !brk_valid_o |-> $stable(brk_code_o)); // R8
endmodule

bind ps2_scan_reader ps2_scan_reader_chk chk_i (
  .clk(clk), .rst(rst), .make_valid_o(make_valid_o), .make_code_o(make_code_o),
  .brk_valid_o(brk_valid_o), .brk_code_o(brk_code_o), .parity_err_o(parity_err_o)
);

// File: tb/ps2_scan_reader_tb_top.sv
module ps2_scan_reader_tb_top;
  localparam int HALF    = 20;
  localparam int GAP     = 60;
  localparam int TMO     = 200;
  localparam int NVEC    = 6;
  localparam int MAX_CYC = 150000;

  typedef struct packed {
    logic [1:0] nf;
    logic [7:0] b0, b1, b2;
    logic [7:0] mk;
    logic       bv;
    logic [7:0] bk;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{2'd3, 8'h1C, 8'hF0, 8'h1C, 8'h1C, 1'b1, 8'h1C},
    '{2'd3, 8'h32, 8'hF0, 8'h32, 8'h32, 1'b1, 8'h32},
    '{2'd2, 8'h45, 8'h29, 8'h00, 8'h45, 1'b0, 8'h00},
    '{2'd2, 8'h16, 8'h16, 8'h00, 8'h16, 1'b0, 8'h00},
    '{2'd3, 8'h01, 8'hF0, 8'h80, 8'h01, 1'b1, 8'h80},
    '{2'd3, 8'h5A, 8'hF0, 8'h5A, 8'h5A, 1'b1, 8'h5A}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pclk = 1'b1;
  logic       pdat = 1'b1;
  logic       make_valid_o, brk_valid_o, parity_err_o;
  logic [7:0] make_code_o, brk_code_o;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int n_make = 0, n_brk = 0, n_perr = 0;
  logic [7:0] last_make = 8'h00, last_brk = 8'h00;

  always #2 clk = ~clk;

  ps2_scan_reader #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .ps2_clk_i(pclk), .ps2_dat_i(pdat),
    .make_valid_o(make_valid_o), .make_code_o(make_code_o),
    .brk_valid_o(brk_valid_o), .brk_code_o(brk_code_o),
    .parity_err_o(parity_err_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (make_valid_o) begin n_make++; last_make = make_code_o; end
      if (brk_valid_o)  begin n_brk++;  last_brk  = brk_code_o;  end
      if (parity_err_o) n_perr++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<=%0d cycles", cyc, MAX_CYC);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic [10:0] f;
    f = {~bad_stop, ~(^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      pdat = f[i];
      wait_cyc(HALF);
      pclk = 1'b0;
      wait_cyc(HALF);
      pclk = 1'b1;
    end
    pdat = 1'b1;
    wait_cyc(GAP);
  endtask

  task automatic send_partial(input int nbits);
    for (int i = 0; i < nbits; i++) begin
      pdat = (i == 0) ? 1'b0 : 1'b1;
      wait_cyc(HALF);
      pclk = 1'b0;
      wait_cyc(HALF);
      pclk = 1'b1;
    end
    pdat = 1'b1;
  endtask

  initial begin
    int m0, b0, p0;
    logic [7:0] brk_keep;
    wait_cyc(5);
    // R1: reset state
    check(make_valid_o == 0 && brk_valid_o == 0 && parity_err_o == 0, "R1 strobes", 
          {make_valid_o, brk_valid_o, parity_err_o}, 0);
    check(make_code_o == 8'h00 && brk_code_o == 8'h00, "R1 codes",
          {make_code_o, brk_code_o}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(make_valid_o == 0 && brk_valid_o == 0 && make_code_o == 0 && brk_code_o == 0,
          "R1 after release", {make_code_o, brk_code_o}, 0);
    wait_cyc(20);

    for (int v = 0; v < NVEC; v++) begin
      m0 = n_make; b0 = n_brk; p0 = n_perr; brk_keep = brk_code_o;
      send_frame(VEC[v].b0, 1'b0, 1'b0);
      send_frame(VEC[v].b1, 1'b0, 1'b0);
      if (VEC[v].nf == 2'd3) send_frame(VEC[v].b2, 1'b0, 1'b0);
      check(n_make - m0 == 1, "R3 make strobe count", n_make - m0, 1);
      check(last_make == VEC[v].mk, "R2 R3 make code", last_make, VEC[v].mk);
      if (VEC[v].bv) begin
        check(n_brk - b0 == 1, "R4 release strobe count", n_brk - b0, 1);
        check(last_brk == VEC[v].bk, "R4 release code", last_brk, VEC[v].bk);
      end else begin
        check(n_brk == b0, "R5 no release strobe", n_brk - b0, 0);
        check(brk_code_o == brk_keep, "R8 release code held", brk_code_o, brk_keep);
      end
      check(n_perr == p0, "R6 no error on clean frames", n_perr - p0, 0);
    end

    // R6: bad parity in the first frame
    m0 = n_make; b0 = n_brk; p0 = n_perr;
    send_frame(8'h3B, 1'b1, 1'b0);
    send_frame(8'hF0, 1'b0, 1'b0);
    send_frame(8'h3B, 1'b0, 1'b0);
    check(n_perr - p0 == 1, "R6 parity error pulse", n_perr - p0, 1);
    check(n_make - m0 == 1 && last_make == 8'h3B, "R6 make unaffected", last_make, 8'h3B);
    check(n_brk - b0 == 1 && last_brk == 8'h3B, "R6 release unaffected", last_brk, 8'h3B);

    // R6: bad stop bit in the third frame
    m0 = n_make; b0 = n_brk; p0 = n_perr;
    send_frame(8'h1C, 1'b0, 1'b0);
    send_frame(8'hF0, 1'b0, 1'b0);
    send_frame(8'h2A, 1'b0, 1'b1);
    check(n_perr - p0 == 1, "R6 stop error pulse", n_perr - p0, 1);
    check(n_brk - b0 == 1 && last_brk == 8'h2A, "R6 release with bad stop", last_brk, 8'h2A);

    // R7: abandoned frame, then a full event
    m0 = n_make; b0 = n_brk; p0 = n_perr;
    send_partial(4);
    wait_cyc(2 * TMO + 100);
    check(n_make == m0 && n_perr == p0, "R7 no output from partial frame", n_make - m0, 0);
    send_frame(8'h66, 1'b0, 1'b0);
    send_frame(8'hF0, 1'b0, 1'b0);
    send_frame(8'h66, 1'b0, 1'b0);
    check(n_make - m0 == 1 && last_make == 8'h66, "R7 make after timeout", last_make, 8'h66);
    check(n_brk - b0 == 1 && last_brk == 8'h66, "R7 release after timeout", last_brk, 8'h66);
    check(n_perr == p0, "R7 no error after timeout", n_perr - p0, 0);

    // R8: codes held long after the strobes
    wait_cyc(300);
    check(make_code_o == 8'h66, "R8 make code held", make_code_o, 8'h66);
    check(brk_code_o == 8'h66, "R8 release code held", brk_code_o, 8'h66);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule